// File: doc/BRIEF.md
# Dual-Channel DAC Write Sequencer

This block sits on the host side of a two-channel, 12-bit, parallel-input converter whose data port is only 8 bits wide. Each channel holds two latch stages: writes land in an input stage, and a separate active-low load strobe copies the input stages into the stages that drive the analog outputs. The sequencer takes a 12-bit code, splits it into a low byte and a high nibble, and places both parts on the bus. It drives the register-select lines, chip select and an active-low write strobe with cycle-counted setup, pulse and hold windows. It then ends the sequence with a load pulse.

A start strobe launches a sequence. In single mode, a channel select picks whether the code for channel A or channel B is written. In update-both mode, all four writes are done first (both parts of A, then both parts of B) and a single load pulse follows, so both outputs change together. Timing limits are parameters in nanoseconds. They are rounded up to whole cycles of the configured clock period. A busy output marks the span of a sequence, and start requests made during that span are dropped.

Top module: `dac_wr_seq`

## Requirements
- R1: While the active-low reset is asserted and right after it is released: cs_no, wr_no and ldac_no are 1, db_o and addr_o are 0, and busy_o is 0.
- R2: In single mode (both_i=0), a start writes the selected code (chan_i=0 picks value_a_i, 1 picks value_b_i) as two writes, followed by one load pulse. The first write carries the low byte, db_o=code[7:0], at addr_o={chan,0}. The second carries the high nibble, db_o={4'b0000,code[11:8]}, at addr_o={chan,1}. Register-select encoding: 00 A low byte, 01 A high nibble, 10 B low byte, 11 B high nibble.
- R3: In update-both mode (both_i=1, chan_i ignored), the writes come in the order 00 (A low), 01 (A high), 10 (B low), 11 (B high), and exactly one load pulse follows the fourth write.
- R4: Each write strobe is low for exactly WR_CYC = ceil(T_WR_NS/CLK_NS) cycles, which is 10 at the defaults (10 ns clock, 100 ns).
- R5: In the cycle before wr_no falls, cs_no is already 0 and addr_o/db_o already hold their write values. These stay unchanged while wr_no is low. Data is therefore valid at least ceil((T_DS_NS+1)/CLK_NS) = 9 cycles before the rising edge.
- R6: After wr_no rises, cs_no stays 0 and addr_o/db_o stay unchanged for HD_CYC = max(1, ceil((T_DH_NS+1)/CLK_NS)) = 2 cycles, counting the cycle of the rise.
- R7: The load strobe ldac_no is low for exactly LD_CYC = ceil((T_LD_NS+1)/CLK_NS) = 11 cycles, with cs_no and wr_no high for the whole pulse.
- R8: busy_o rises in the cycle after a start is accepted and falls in the same cycle that ldac_no is released. It is high for 37 cycles in single mode and 63 cycles in update-both mode at the defaults.
- R9: A start that arrives while busy_o is 1 has no effect, and changes to the value, channel or mode inputs during a sequence have no effect. The running sequence puts out the codes captured at its start, with no extra writes and no change in busy length.
- R10: Whenever busy_o is 0, db_o is 0 and cs_no, wr_no and ldac_no are 1.
- R11: Asserting the reset in the middle of a sequence returns the outputs to the R1 state at once, without waiting for a clock edge. No write or load follows until the next start, and a later start then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| both_i | input | 1 | 1: write both channels, then load once |
| chan_i | input | 1 | Channel for single mode (0 = A, 1 = B) |
| value_a_i | input | CODE_W | Code for channel A |
| value_b_i | input | CODE_W | Code for channel B |
| db_o | output | BUS_W | Converter data bus |
| addr_o | output | 2 | Register-select lines |
| cs_no | output | 1 | Chip select, active low |
| wr_no | output | 1 | Write strobe, active low |
| ldac_no | output | 1 | Load strobe, active low |
| busy_o | output | 1 | Sequence in progress |

## Verification
The hardest situations to reach from the ports are a start request that collides with a running sequence and a reset that lands mid-write. The first case also involves input values that change after capture. The stimulus pulses a second start in update-both mode with new codes partway through a single-mode sequence. The scoreboard then must still see only the two original writes, one load and a 37-cycle busy span. In the second case, reset is asserted while a second write of an update-both sequence is in flight. The bench checks that the outputs go inactive within the same clock period and that no event appears in the 80 cycles that follow.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_LOAD
  } seq_state_e;

  function automatic int ceil_div(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/dac_seq_frame.sv
module dac_seq_frame #(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              both_i,
  input  logic              chan_i,
  input  logic [CODE_W-1:0] value_a_i,
  input  logic [CODE_W-1:0] value_b_i,
  input  logic              busy_i,
  input  logic              drive_i,
  input  logic [1:0]        step_i,
  output logic              last_o,
  output logic [1:0]        addr_o,
  output logic [BUS_W-1:0]  db_o
);

  logic              both_q, chan_q;
  logic [CODE_W-1:0] code_a_q, code_b_q;
  logic [1:0]        addr;
  logic [CODE_W-1:0] code;
  logic [BUS_W-1:0]  part;

  // capture request at acceptance; inputs are don't-care afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      both_q   <= 1'b0;
      chan_q   <= 1'b0;
      code_a_q <= '0;
      code_b_q <= '0;
    end else if (accept_i) begin
      both_q   <= both_i;
      chan_q   <= chan_i;
      code_a_q <= value_a_i;
      code_b_q <= value_b_i;
    end
  end

  // addr[1] = channel, addr[0] = high part
  always_comb begin
    addr = both_q ? step_i : {chan_q, step_i[0]};
    code = addr[1] ? code_b_q : code_a_q;
    part = addr[0] ? BUS_W'(code[CODE_W-1:BUS_W]) : code[BUS_W-1:0];
  end

  assign last_o = both_q ? (step_i == 2'd3) : (step_i == 2'd1);
  assign addr_o = drive_i ? addr : 2'b00;
  assign db_o   = drive_i ? part : '0;

  // R9
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> ($stable(code_a_q) && $stable(code_b_q) &&
                                   $stable(both_q) && $stable(chan_q)));

endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int SU_CYC = 1,
  parameter int WR_CYC = 10,
  parameter int HD_CYC = 2,
  parameter int LD_CYC = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             last_i,
  input  logic             done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic [1:0]       step_o,
  output logic             drive_o,
  output logic             cs_no,
  output logic             wr_no,
  output logic             ldac_no,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] SuVal = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] WrVal = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] HdVal = CNT_W'(HD_CYC - 1);
  localparam logic [CNT_W-1:0] LdVal = CNT_W'(LD_CYC - 1);

  seq_state_e state_q, state_d;
  logic [1:0] step_q, step_d;

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    accept_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d    = ST_SETUP;
        step_d     = 2'd0;
        tmr_load_o = 1'b1;
        tmr_val_o  = SuVal;
        accept_o   = 1'b1;
      end
      ST_SETUP: if (done_i) begin
        state_d    = ST_STROBE;
        tmr_load_o = 1'b1;
        tmr_val_o  = WrVal;
      end
      ST_STROBE: if (done_i) begin
        state_d    = ST_HOLD;
        tmr_load_o = 1'b1;
        tmr_val_o  = HdVal;
      end
      ST_HOLD: if (done_i) begin
        tmr_load_o = 1'b1;
        if (last_i) begin
          state_d   = ST_LOAD;
          tmr_val_o = LdVal;
        end else begin
          state_d   = ST_SETUP;
          step_d    = step_q + 2'd1;
          tmr_val_o = SuVal;
        end
      end
      ST_LOAD: if (done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= 2'd0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign step_o  = step_q;
  assign drive_o = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign cs_no   = !drive_o;
  assign wr_no   = (state_q != ST_STROBE);
  assign ldac_no = (state_q != ST_LOAD);
  assign busy_o  = (state_q != ST_IDLE);

  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R8
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ldac_no) |-> !busy_o);

  // R6
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> !cs_no);

  // R3
  load_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ldac_no) |-> ($past(!cs_no) && $past(wr_no)));

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_seq_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int T_WR_NS = 100,
  parameter int T_DS_NS = 80,
  parameter int T_DH_NS = 10,
  parameter int T_LD_NS = 100,
  parameter int CODE_W  = 12,
  parameter int BUS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              both_i,
  input  logic              chan_i,
  input  logic [CODE_W-1:0] value_a_i,
  input  logic [CODE_W-1:0] value_b_i,
  output logic [BUS_W-1:0]  db_o,
  output logic [1:0]        addr_o,
  output logic              cs_no,
  output logic              wr_no,
  output logic              ldac_no,
  output logic              busy_o
);

  // minimums given as "more than" get one extra ns before rounding up
  localparam int WrCyc  = imax(1, ceil_div(T_WR_NS, CLK_NS));
  localparam int DsCyc  = ceil_div(T_DS_NS + 1, CLK_NS);
  localparam int DhCyc  = ceil_div(T_DH_NS + 1, CLK_NS);
  localparam int LdCyc  = imax(1, ceil_div(T_LD_NS + 1, CLK_NS));
  localparam int SuCyc  = imax(1, DsCyc - WrCyc);
  localparam int HdCyc  = imax(1, DhCyc);
  localparam int MaxCyc = imax(imax(WrCyc, LdCyc), imax(SuCyc, HdCyc));
  localparam int CntW   = $clog2(MaxCyc + 1);

  logic            tmr_load, tmr_done, accept, last, drive;
  logic [CntW-1:0] tmr_val;
  logic [1:0]      step;

  dac_seq_timer #(.CNT_W(CntW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  dac_seq_ctrl #(
    .CNT_W  (CntW),
    .SU_CYC (SuCyc),
    .WR_CYC (WrCyc),
    .HD_CYC (HdCyc),
    .LD_CYC (LdCyc)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_i     (last),
    .done_i     (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .accept_o   (accept),
    .step_o     (step),
    .drive_o    (drive),
    .cs_no      (cs_no),
    .wr_no      (wr_no),
    .ldac_no    (ldac_no),
    .busy_o     (busy_o)
  );

  dac_seq_frame #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .both_i    (both_i),
    .chan_i    (chan_i),
    .value_a_i (value_a_i),
    .value_b_i (value_b_i),
    .busy_i    (busy_o),
    .drive_i   (drive),
    .step_i    (step),
    .last_o    (last),
    .addr_o    (addr_o),
    .db_o      (db_o)
  );

  // pulse-width counters used by the checks below
  int wr_low_q, ld_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_low_q <= 0;
      ld_low_q <= 0;
    end else begin
      wr_low_q <= !wr_no ? wr_low_q + 1 : 0;
      ld_low_q <= !ldac_no ? ld_low_q + 1 : 0;
    end
  end

  // R4
  wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> (wr_low_q == WrCyc));

  // R7
  ld_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ldac_no) |-> (ld_low_q == LdCyc));

  // R5
  wr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> ($past(!cs_no) && $stable(addr_o) && $stable(db_o)));

  // R5
  wr_data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no && $past(!wr_no)) |-> ($stable(addr_o) && $stable(db_o)));

  // R10
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (db_o == '0 && cs_no && wr_no && ldac_no));

endmodule

// File: tb/tb_dac_wr_seq.sv
module tb_dac_wr_seq;

  localparam int CLK_NS = 10;
  // expected timing, derived from the requirement formulas
  localparam int WR_EXP  = (100 + CLK_NS - 1) / CLK_NS;
  localparam int DS_EXP  = (81 + CLK_NS - 1) / CLK_NS;
  localparam int HD_EXP  = (11 + CLK_NS - 1) / CLK_NS;
  localparam int LD_EXP  = (101 + CLK_NS - 1) / CLK_NS;
  localparam int SU_EXP  = (DS_EXP - WR_EXP > 1) ? DS_EXP - WR_EXP : 1;
  localparam int WRITE_T = SU_EXP + WR_EXP + HD_EXP;
  localparam int LEN_ONE = 2 * WRITE_T + LD_EXP;
  localparam int LEN_TWO = 4 * WRITE_T + LD_EXP;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        start_i = 1'b0, both_i = 1'b0, chan_i = 1'b0;
  logic [11:0] value_a_i = '0, value_b_i = '0;
  logic [7:0]  db_o;
  logic [1:0]  addr_o;
  logic        cs_no, wr_no, ldac_no, busy_o;

  dac_wr_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .both_i(both_i), .chan_i(chan_i),
    .value_a_i(value_a_i), .value_b_i(value_b_i), .db_o(db_o), .addr_o(addr_o),
    .cs_no(cs_no), .wr_no(wr_no), .ldac_no(ldac_no), .busy_o(busy_o)
  );

  always #(CLK_NS / 2) clk_i = ~clk_i;

  typedef struct {
    bit         ld;
    logic [1:0] addr;
    logic [7:0] data;
    string      req;
  } ev_t;

  ev_t sb[$];
  int  n_chk = 0, n_fail = 0, n_evt = 0, exp_len = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_w(input logic [1:0] a, input logic [7:0] d, input string req);
    ev_t e;
    e.ld = 0; e.addr = a; e.data = d; e.req = req;
    sb.push_back(e);
  endtask

  task automatic push_l(input string req);
    ev_t e;
    e.ld = 1; e.addr = 2'b00; e.data = 8'h00; e.req = req;
    sb.push_back(e);
  endtask

  task automatic launch(input bit both, input bit chan, input logic [11:0] a, input logic [11:0] b);
    logic [11:0] c;
    if (both) begin
      push_w(2'b00, a[7:0], "R3");
      push_w(2'b01, {4'b0000, a[11:8]}, "R3");
      push_w(2'b10, b[7:0], "R3");
      push_w(2'b11, {4'b0000, b[11:8]}, "R3");
      push_l("R3");
      exp_len = LEN_TWO;
    end else begin
      c = chan ? b : a;
      push_w({chan, 1'b0}, c[7:0], "R2");
      push_w({chan, 1'b1}, {4'b0000, c[11:8]}, "R2");
      push_l("R2");
      exp_len = LEN_ONE;
    end
    @(negedge clk_i);
    both_i = both; chan_i = chan; value_a_i = a; value_b_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(db_o == 8'h00 && cs_no && wr_no && ldac_no, "R10", "idle outputs",
        {db_o, cs_no, wr_no, ldac_no}, {8'h00, 3'b111});
    chk(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
  endtask

  // monitor / scoreboard
  logic       p_wr = 1, p_cs = 1, p_ld = 1, p_busy = 0;
  logic [1:0] p_addr = 0, cap_addr = 0;
  logic [7:0] p_db = 0, cap_db = 0;
  int         low_n = 0, ld_n = 0, busy_n = 0, hold_left = 0;

  always @(negedge clk_i) begin
    ev_t e;
    if (!rst_ni) begin
      low_n = 0; ld_n = 0; busy_n = 0; hold_left = 0;
    end else begin
      // write strobe
      if (p_wr && !wr_no) begin
        chk(!p_cs && p_addr == addr_o && p_db == db_o, "R5", "setup before wr fall",
            {p_cs, p_addr, p_db}, {1'b0, addr_o, db_o});
        cap_addr = addr_o; cap_db = db_o; low_n = 1;
      end else if (!wr_no) begin
        low_n++;
        if (addr_o != cap_addr || db_o != cap_db)
          chk(0, "R5", "data moved while wr low", {addr_o, db_o}, {cap_addr, cap_db});
      end
      if (!p_wr && wr_no) begin
        chk(low_n == WR_EXP, "R4", "wr low width", low_n, WR_EXP);
        hold_left = HD_EXP;
        if (sb.size() == 0) chk(0, "R9", "unexpected write", {cap_addr, cap_db}, 0);
        else begin
          e = sb.pop_front();
          n_evt++;
          chk(!e.ld && e.addr == cap_addr && e.data == cap_db, e.req, "write addr/data",
              {e.ld, cap_addr, cap_db}, {1'b0, e.addr, e.data});
        end
      end
      if (hold_left > 0 && wr_no) begin
        chk(!cs_no && addr_o == cap_addr && db_o == cap_db, "R6", "hold after wr rise",
            {cs_no, addr_o, db_o}, {1'b0, cap_addr, cap_db});
        hold_left--;
      end
      // load strobe
      if (!ldac_no) begin
        ld_n++;
        if (!cs_no || !wr_no) chk(0, "R7", "cs/wr active during load", {cs_no, wr_no}, 2'b11);
      end
      if (!p_ld && ldac_no) begin
        chk(ld_n == LD_EXP, "R7", "load low width", ld_n, LD_EXP);
        chk(!busy_o, "R8", "busy released with load", busy_o, 0);
        ld_n = 0;
        if (sb.size() == 0) chk(0, "R9", "unexpected load", 1, 0);
        else begin
          e = sb.pop_front();
          n_evt++;
          chk(e.ld, e.req, "load pulse position", 1, e.ld);
        end
      end
      // busy span
      if (busy_o) busy_n++;
      if (p_busy && !busy_o) begin
        chk(busy_n == exp_len, "R8", "busy length", busy_n, exp_len);
        busy_n = 0;
      end
    end
    p_wr = wr_no; p_cs = cs_no; p_ld = ldac_no; p_busy = busy_o;
    p_addr = addr_o; p_db = db_o;
  end

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: busy never settled, actual 1 expected 0");
      summary();
    end
  end

  initial begin
    int snap;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(cs_no && wr_no && ldac_no && db_o == 0 && addr_o == 0 && !busy_o, "R1", "reset state",
        {cs_no, wr_no, ldac_no, db_o, addr_o, busy_o}, {3'b111, 8'h00, 2'b00, 1'b0});
    #(CLK_NS / 4) rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(cs_no && wr_no && ldac_no && db_o == 0 && addr_o == 0 && !busy_o, "R1", "after release",
        {cs_no, wr_no, ldac_no, db_o, addr_o, busy_o}, {3'b111, 8'h00, 2'b00, 1'b0});

    // R2 single writes to each channel
    launch(0, 0, 12'hABC, 12'h000); wait_idle();
    launch(0, 1, 12'h000, 12'h5F3); wait_idle();
    // R3 both, chan_i=1 must not matter
    launch(1, 1, 12'h123, 12'hFED); wait_idle();
    // boundary codes
    launch(0, 0, 12'hFFF, 12'h000); wait_idle();
    launch(0, 1, 12'hFFF, 12'h000); wait_idle();
    launch(1, 0, 12'h000, 12'hFFF); wait_idle();

    // R9 start and input changes while busy
    launch(0, 0, 12'h456, 12'h789);
    repeat (10) @(negedge clk_i);
    start_i = 1'b1; both_i = 1'b1; chan_i = 1'b1; value_a_i = 12'h999; value_b_i = 12'h111;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    value_a_i = 12'h0F0;
    wait_idle();

    // R11 reset mid-sequence
    launch(1, 0, 12'h321, 12'h654);
    repeat (20) @(negedge clk_i);
    #(CLK_NS / 4) rst_ni = 1'b0;
    sb.delete();
    #1;
    chk(cs_no && wr_no && ldac_no && db_o == 0 && !busy_o, "R11", "async reset mid-sequence",
        {cs_no, wr_no, ldac_no, db_o, busy_o}, {3'b111, 8'h00, 1'b0});
    snap = n_evt;
    @(negedge clk_i);
    #(CLK_NS / 4) rst_ni = 1'b1;
    repeat (80) @(negedge clk_i);
    chk(n_evt == snap && ldac_no && wr_no, "R11", "no events after reset", n_evt, snap);
    launch(0, 0, 12'h777, 12'h000); wait_idle();

    summary();
  end

endmodule